// File: doc/BRIEF.md
# Prefix-Extended Branch and Immediate Unit

This unit serves a small CPU that works on 4-bit data and fetches 13-bit instruction words. Such a word has room for at most an 8-bit immediate field. A prefix instruction fills that gap: it loads an 8-bit extension register, and the next instruction's 8-bit field supplies the low byte of a 16-bit operand. When no prefix is pending, the field is widened by itself. Branches, calls and adds sign-extend it. Loads and compares zero-extend it.

The 16-bit operand drives four kinds of work.
- Relative jumps and calls. These can be unconditional, or conditional on the carry or zero flag. The unit computes the next program counter in the same cycle that the instruction is presented.
- Calls. A call also saves the return address on the data stack, one nibble per cycle, and the unit holds a busy line while it does so.
- Index registers. The unit holds the two 16-bit index registers X and Y. It loads them or adds to them.
- Compares. A compare against X or Y only produces new carry and zero flags.

Instruction fetch, full decode and the 4-bit data path sit outside the unit. The unit sees only an operation class, the raw 8-bit field, the program counter, the two flags and the stack pointer. While a prefix is pending, it tells the interrupt logic to hold off, so that the high byte cannot be lost or attached to the wrong instruction.

Top module: `ext_branch_unit`

## Requirements
- R1: An accepted op with op_class 1 (prefix) stores imm8 as the high operand byte and marks a prefix pending from the next cycle on.
- R2: The 16-bit operand is {stored byte, imm8} when a prefix is pending. Otherwise imm8 is sign-extended for classes 2 to 7 and 10 to 11, and zero-extended for classes 8 to 9 and 12 to 13.
- R3: An accepted jump (class 2) or call (class 7) drives pc_load high and next_pc = pc + operand + 1 in the same cycle, with the result wrapping modulo 2^16.
- R4: Conditional jumps are taken only when their condition holds: class 3 when C = 1, class 4 when C = 0, class 5 when Z = 1, class 6 when Z = 0. When a jump is not taken, pc_load is low and next_pc = pc + 1.
- R5: An accepted call pulses sp1_dec in its own cycle. Over the next four cycles the unit holds busy and push_we high and writes the nibbles of pc + 1, least significant first, to addresses (sp1 - 1)*4 + 0 through + 3. Here sp1 - 1 wraps within 8 bits.
- R6: Class 8 loads the operand into X, and class 9 loads it into Y. The new value is visible after the accepting clock edge.
- R7: Class 10 writes X + operand back to X, and class 11 writes Y + operand back to Y, both modulo 2^16.
- R8: Class 12 compares X with the operand, and class 13 compares Y with the operand. In the accepting cycle flag_we is high, new_c = 1 when the register is below the operand (unsigned), and new_z = 1 when the two are equal. X and Y stay unchanged.
- R9: A pending prefix is cleared by the next accepted op of any class other than 1, even one that does not use the operand, such as class 0.
- R10: irq_hold is high exactly while a prefix is pending.
- R11: While busy is high, op_valid is ignored. Registers do not change, pc_load stays low and no new push starts.
- R12: After reset X = 0, Y = 0, busy = 0, push_we = 0 and irq_hold = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_class | input | 4 | Operation class, encoded as listed in R1 to R9 |
| imm8 | input | 8 | 8-bit immediate field of the instruction |
| pc | input | 16 | Address of the current instruction |
| flag_c | input | 1 | Current carry flag |
| flag_z | input | 1 | Current zero flag |
| sp1 | input | 8 | Current stack pointer |
| next_pc | output | 16 | Next program counter |
| pc_load | output | 1 | Branch or call taken this cycle |
| reg_x | output | 16 | Index register X |
| reg_y | output | 16 | Index register Y |
| flag_we | output | 1 | Compare flag update strobe |
| new_c | output | 1 | Carry flag result of a compare |
| new_z | output | 1 | Zero flag result of a compare |
| push_we | output | 1 | Stack nibble write strobe |
| push_addr | output | 10 | Stack nibble address |
| push_data | output | 4 | Stack nibble data |
| sp1_dec | output | 1 | Decrement stack pointer by one |
| busy | output | 1 | Return-address push in progress |
| irq_hold | output | 1 | Block interrupt acceptance |

## Verification
A pending flag that is stuck or cleared too early shows up on the very next operand-consuming op. A load of X gives a high byte of 00 or of the stale byte, and irq_hold reads wrong one cycle after the prefix. A wrong push counter or base latch shows up within four cycles of a call, as a misplaced or misordered nibble in the push stream, which the bench checks entry by entry against the expected return address. Ops slipping past a busy unit appear as a changed X once the push completes.

// File: rtl/ext_branch_unit.sv
module ext_branch_unit #(
  parameter int EXT_W = 8,
  parameter int NIB_W = 4,
  parameter int SP_W  = 8,
  parameter int CLS_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [CLS_W-1:0]     op_class,
  input  logic [EXT_W-1:0]     imm8,
  input  logic [2*EXT_W-1:0]   pc,
  input  logic                 flag_c,
  input  logic                 flag_z,
  input  logic [SP_W-1:0]      sp1,
  output logic [2*EXT_W-1:0]   next_pc,
  output logic                 pc_load,
  output logic [2*EXT_W-1:0]   reg_x,
  output logic [2*EXT_W-1:0]   reg_y,
  output logic                 flag_we,
  output logic                 new_c,
  output logic                 new_z,
  output logic                 push_we,
  output logic [SP_W+$clog2(2*EXT_W/NIB_W)-1:0] push_addr,
  output logic [NIB_W-1:0]     push_data,
  output logic                 sp1_dec,
  output logic                 busy,
  output logic                 irq_hold
);
  localparam int OPND_W = 2 * EXT_W;
  localparam int NIBS   = OPND_W / NIB_W;
  localparam int CNT_W  = $clog2(NIBS);

  localparam logic [CLS_W-1:0] C_PFX  = CLS_W'(1);
  localparam logic [CLS_W-1:0] C_JR   = CLS_W'(2);
  localparam logic [CLS_W-1:0] C_JRC  = CLS_W'(3);
  localparam logic [CLS_W-1:0] C_JRNC = CLS_W'(4);
  localparam logic [CLS_W-1:0] C_JRZ  = CLS_W'(5);
  localparam logic [CLS_W-1:0] C_JRNZ = CLS_W'(6);
  localparam logic [CLS_W-1:0] C_CALL = CLS_W'(7);
  localparam logic [CLS_W-1:0] C_LDX  = CLS_W'(8);
  localparam logic [CLS_W-1:0] C_LDY  = CLS_W'(9);
  localparam logic [CLS_W-1:0] C_ADDX = CLS_W'(10);
  localparam logic [CLS_W-1:0] C_ADDY = CLS_W'(11);
  localparam logic [CLS_W-1:0] C_CMPX = CLS_W'(12);
  localparam logic [CLS_W-1:0] C_CMPY = CLS_W'(13);

  logic              pend_q;
  logic [EXT_W-1:0]  ext_q;
  logic [OPND_W-1:0] x_q, y_q, ret_q;
  logic [SP_W-1:0]   base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;

  logic accept, is_pfx, is_br, is_call, is_ld, is_add, is_cmp, sext, cond, sel_y;
  logic [OPND_W-1:0] operand, pc_inc, target, src, sum;
  logic [OPND_W:0]   diff;

  assign accept  = op_valid & ~busy_q;
  assign is_pfx  = op_class == C_PFX;
  assign is_br   = op_class >= C_JR && op_class <= C_JRNZ;
  assign is_call = op_class == C_CALL;
  assign is_ld   = op_class == C_LDX  || op_class == C_LDY;
  assign is_add  = op_class == C_ADDX || op_class == C_ADDY;
  assign is_cmp  = op_class == C_CMPX || op_class == C_CMPY;
  assign sext    = is_br | is_call | is_add;
  assign sel_y   = op_class[0];

  assign operand = pend_q ? {ext_q, imm8}
                 : sext   ? {{EXT_W{imm8[EXT_W-1]}}, imm8}
                          : {{EXT_W{1'b0}}, imm8};

  always_comb begin
    case (op_class)
      C_JRC:   cond = flag_c;
      C_JRNC:  cond = ~flag_c;
      C_JRZ:   cond = flag_z;
      C_JRNZ:  cond = ~flag_z;
      default: cond = 1'b1;
    endcase
  end

  assign pc_inc  = pc + OPND_W'(1);
  assign target  = pc_inc + operand;
  assign pc_load = accept & (is_call | (is_br & cond));
  assign next_pc = pc_load ? target : pc_inc;

  assign src     = sel_y ? y_q : x_q;
  assign sum     = src + operand;
  assign diff    = {1'b0, src} - {1'b0, operand};
  assign flag_we = accept & is_cmp;
  assign new_c   = diff[OPND_W];
  assign new_z   = diff[OPND_W-1:0] == '0;

  assign sp1_dec   = accept & is_call;
  assign push_we   = busy_q;
  assign push_addr = {base_q, cnt_q};
  assign push_data = NIB_W'(ret_q >> (cnt_q * NIB_W));
  assign busy      = busy_q;
  assign irq_hold  = pend_q;
  assign reg_x     = x_q;
  assign reg_y     = y_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ext_q  <= '0;
    end else if (accept) begin
      pend_q <= is_pfx;
      if (is_pfx) ext_q <= imm8;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (accept && (is_ld || is_add)) begin
      if (sel_y) y_q <= is_ld ? operand : sum;
      else       x_q <= is_ld ? operand : sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      ret_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(NIBS - 1)) busy_q <= 1'b0;
    end else if (accept && is_call) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      base_q <= sp1 - 1'b1;
      ret_q  <= pc_inc;
    end
  end

  // R1
  pfx_sets_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_class == C_PFX) |=> irq_hold);

  // R9
  hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_class != C_PFX) |=> !irq_hold);

  // R5
  push_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp1_dec |=> (push_we && push_addr == {SP_W'($past(sp1) - 1'b1), CNT_W'(0)}));

  // R5
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_we && $past(push_we)) |-> (push_addr == $past(push_addr) + 1'b1));

  // R8
  cmp_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> ($stable(reg_x) && $stable(reg_y)));

  // R11
  busy_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!pc_load && !flag_we && !sp1_dec));
endmodule

// File: tb/ext_branch_unit_tb.sv
module ext_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_class = '0;
  logic [7:0]  imm8 = '0;
  logic [15:0] pc = '0;
  logic        flag_c = 1'b0, flag_z = 1'b0;
  logic [7:0]  sp1 = '0;
  logic [15:0] next_pc, reg_x, reg_y;
  logic        pc_load, flag_we, new_c, new_z, push_we, sp1_dec, busy, irq_hold;
  logic [9:0]  push_addr;
  logic [3:0]  push_data;

  int errors = 0, checks = 0;
  logic [13:0] exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  ext_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class), .imm8(imm8),
    .pc(pc), .flag_c(flag_c), .flag_z(flag_z), .sp1(sp1), .next_pc(next_pc),
    .pc_load(pc_load), .reg_x(reg_x), .reg_y(reg_y), .flag_we(flag_we), .new_c(new_c),
    .new_z(new_z), .push_we(push_we), .push_addr(push_addr), .push_data(push_data),
    .sp1_dec(sp1_dec), .busy(busy), .irq_hold(irq_hold));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] cls, logic [7:0] imm, logic [15:0] p = 16'h0,
                       logic c = 1'b0, logic z = 1'b0, logic [7:0] sp = 8'h0);
    @(negedge clk);
    op_valid = 1'b1; op_class = cls; imm8 = imm; pc = p; flag_c = c; flag_z = z; sp1 = sp;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0; op_class = '0;
    #1;
  endtask

  task automatic call(logic [7:0] pfx, logic use_pfx, logic [7:0] imm, logic [15:0] p,
                      logic [7:0] sp, logic [15:0] exp_tgt);
    logic [15:0] ret;
    logic [7:0]  base;
    ret  = p + 16'd1;
    base = sp - 8'd1;
    if (use_pfx) drive(4'd1, pfx);
    drive(4'd7, imm, p, 1'b0, 1'b0, sp);
    chk("R3 call target", next_pc, exp_tgt);
    chk("R3 call pc_load", pc_load, 1);
    chk("R5 sp1_dec", sp1_dec, 1);
    for (int i = 0; i < 4; i++) exp_q.push_back({base, i[1:0], ret[i*4 +: 4]});
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    #3;
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && push_we) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5 unexpected push: actual=%0h expected=none", {push_addr, push_data});
      end else begin
        logic [13:0] e;
        e = exp_q.pop_front();
        chk("R5 push addr/data", {push_addr, push_data}, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12
    chk("R12 x", reg_x, 0); chk("R12 y", reg_y, 0); chk("R12 busy", busy, 0);
    chk("R12 push_we", push_we, 0); chk("R12 irq_hold", irq_hold, 0);

    drive(4'd8, 8'h85); idle();
    chk("R6 R2 ldx zero-ext", reg_x, 16'h0085);

    drive(4'd1, 8'h12); idle();
    chk("R1 R10 hold after prefix", irq_hold, 1);
    drive(4'd8, 8'h34); idle();
    chk("R1 ldx prefixed", reg_x, 16'h1234);
    chk("R9 hold cleared", irq_hold, 0);

    drive(4'd1, 8'hAB); drive(4'd9, 8'hCD); idle();
    chk("R6 ldy prefixed", reg_y, 16'hABCD);

    drive(4'd10, 8'hF0); idle();
    chk("R7 R2 addx sign-ext", reg_x, 16'h1224);
    drive(4'd1, 8'h01); drive(4'd11, 8'h00); idle();
    chk("R7 addy prefixed", reg_y, 16'hACCD);

    drive(4'd1, 8'h12); drive(4'd12, 8'h24);
    chk("R8 cmp equal we", flag_we, 1); chk("R8 cmp equal z", new_z, 1); chk("R8 cmp equal c", new_c, 0);
    idle();
    chk("R8 x unchanged", reg_x, 16'h1224);
    drive(4'd13, 8'hFF);
    chk("R8 cmpy z", new_z, 0); chk("R8 cmpy c zero-ext", new_c, 0);
    drive(4'd1, 8'hFF); drive(4'd12, 8'hFF);
    chk("R8 cmpx borrow", new_c, 1); chk("R8 cmpx z", new_z, 0);
    idle();
    chk("R8 y unchanged", reg_y, 16'hACCD);

    drive(4'd2, 8'hFE, 16'h1000);
    chk("R3 R2 jr backward", next_pc, 16'h0FFF); chk("R3 jr load", pc_load, 1);
    drive(4'd1, 8'h80); drive(4'd2, 8'h00, 16'h0100);
    chk("R3 jr far", next_pc, 16'h8101);
    drive(4'd1, 8'h7F); drive(4'd2, 8'hFF, 16'h0000);
    chk("R3 jr max wrap", next_pc, 16'h8000);

    drive(4'd3, 8'h10, 16'h0200, 1'b1, 1'b0);
    chk("R4 jrc taken", next_pc, 16'h0211); chk("R4 jrc load", pc_load, 1);
    drive(4'd3, 8'h10, 16'h0200, 1'b0, 1'b0);
    chk("R4 jrc fall", next_pc, 16'h0201); chk("R4 jrc no load", pc_load, 0);
    drive(4'd4, 8'h10, 16'h0200, 1'b0, 1'b1);
    chk("R4 jrnc taken", pc_load, 1);
    drive(4'd4, 8'h10, 16'h0200, 1'b1, 1'b0);
    chk("R4 jrnc fall", pc_load, 0);
    drive(4'd5, 8'h10, 16'h0200, 1'b0, 1'b1);
    chk("R4 jrz taken", pc_load, 1);
    drive(4'd5, 8'h10, 16'h0200, 1'b1, 1'b0);
    chk("R4 jrz fall", next_pc, 16'h0201);
    drive(4'd6, 8'h10, 16'h0200, 1'b1, 1'b0);
    chk("R4 jrnz taken", next_pc, 16'h0211);
    drive(4'd6, 8'h10, 16'h0200, 1'b0, 1'b1);
    chk("R4 jrnz fall", pc_load, 0);

    drive(4'd1, 8'h55); drive(4'd0, 8'h00); drive(4'd8, 8'h10); idle();
    chk("R9 unused prefix dropped", reg_x, 16'h0010);

    call(8'h01, 1'b1, 8'h10, 16'h2345, 8'h10, 16'h2456);
    drive(4'd8, 8'h77);
    chk("R11 busy", busy, 1);
    drive(4'd2, 8'h05, 16'h0300);
    chk("R11 no branch while busy", pc_load, 0);
    idle();
    wait_idle();
    chk("R11 x unchanged", reg_x, 16'h0010);

    call(8'h00, 1'b0, 8'hF0, 16'h0FFF, 8'h00, 16'h0FF0);
    idle();
    wait_idle();
    repeat (2) @(negedge clk);
    chk("R5 all pushes seen", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule